// File: doc/BRIEF.md
# Operand Address Resolver

This block takes a one-operand instruction, held as two 32-bit words, and works out where its operand lives, or what the operand is. The low three bits of the first word select one of seven addressing schemes. The second word is the operand field: a literal, a register number, an address or an offset, depending on the scheme. The block reads a small external register file through a combinational select and read-data pair. It reaches word-addressed memory through an address register and a request/ready read port. When the answer is ready, it presents it on `result` with a single-cycle `done` strobe.

The indirection chain and the order of index addition relative to it are the core of the block. A pre-indexed scheme adds the index register before the memory read. A post-indexed scheme adds it to the word that comes back. Instruction fetch, execution and write-back belong to neighbouring blocks.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `instr_ready` is 1 and `done`, `mem_rd_req` and `illegal` are 0.
- R2: Mode 0 (literal, word0[2:0]=0) returns word1 on `result` with `result_is_value`=1 and issues no memory read.
- R3: Mode 1 (register) drives `reg_sel` with word1[2:0] and returns that register's contents with `result_is_value`=1, without any memory read.
- R4: Mode 2 (absolute) returns word1 as the effective address with `result_is_value`=0 and no memory read.
- R5: Mode 3 (memory-indirect) issues exactly one read at address word1 and returns the word read as the effective address.
- R6: Mode 4 (offset) returns word1 plus the index register selected by word0[10:8], modulo 2^32, and issues no memory read.
- R7: Mode 5 (offset-then-indirect) issues one read at word1 plus the index register and returns the word read.
- R8: Mode 6 (indirect-then-offset) issues one read at word1 and returns the word read plus the index register, modulo 2^32.
- R9: While `mem_rd_req` is 1 and `mem_ready` is 0, the request stays high and `mem_addr` holds its value. Read data is taken only in the cycle where `mem_ready` is 1.
- R10: Mode 7 raises `illegal` together with `done` and issues no memory read.
- R11: `done` is high for exactly one cycle, after which `instr_ready` returns to 1. `instr_ready` is 0 while an instruction is in progress.
- R12: Bits of word0 outside the mode field [2:0] and the index field [10:8] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | Block is idle and accepts an instruction |
| instr_word0 | input | 32 | Opcode word: mode [2:0], index register [10:8] |
| instr_word1 | input | 32 | Operand field |
| reg_sel | output | 3 | Register file read select |
| reg_rdata | input | 32 | Register file read data (combinational) |
| mem_rd_req | output | 1 | Memory read command |
| mem_addr | output | 32 | Memory address register |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Memory data register contents |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Effective address or operand value |
| result_is_value | output | 1 | 1 when `result` is an operand, 0 when it is an address |
| illegal | output | 1 | Reserved mode seen, valid with `done` |

## Verification
The bench sweeps all eight mode codes, every index register and four operand fields. The operand fields are zero, a small offset, a value near the top of the address range and a scattered bit pattern. The near-top value makes the additions wrap, which tells offset addition apart from a saturating or width-truncated sum. Memory and register contents come from distinct arithmetic functions of their address. As a result, pre-indexed and post-indexed results differ whenever the index is non-zero, so swapped ordering is exposed. The read latency rotates from zero to three cycles while garbage sits on the data bus. This separates capture on the ready cycle from early capture. Random upper bits in word0 show that only the two decoded fields matter.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [2:0] {
        AM_LIT  = 3'd0,
        AM_REG  = 3'd1,
        AM_ABS  = 3'd2,
        AM_IND  = 3'd3,
        AM_OFS  = 3'd4,
        AM_PRE  = 3'd5,
        AM_POST = 3'd6,
        AM_RSVD = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_READ,
        ST_DONE
    } seq_e;

    typedef struct packed {
        logic is_value;
        logic from_reg;
        logic add_before;
        logic mem_read;
        logic add_after;
        logic bad;
    } plan_t;

endpackage

// File: rtl/opaddr_decode.sv
module opaddr_decode
    import opaddr_pkg::*;
(
    input  amode_e mode,
    output plan_t  plan
);

    always_comb begin
        plan = '0;
        unique case (mode)
            AM_LIT:  plan.is_value   = 1'b1;
            AM_REG: begin
                plan.is_value = 1'b1;
                plan.from_reg = 1'b1;
            end
            AM_ABS:  plan.add_before = 1'b0;
            AM_IND:  plan.mem_read   = 1'b1;
            AM_OFS:  plan.add_before = 1'b1;
            AM_PRE: begin
                plan.add_before = 1'b1;
                plan.mem_read   = 1'b1;
            end
            AM_POST: begin
                plan.mem_read  = 1'b1;
                plan.add_after = 1'b1;
            end
            AM_RSVD: plan.bad = 1'b1;
            default: plan.bad = 1'b1;
        endcase
    end

    // R10
    plan_excl_chk: assert final (!(plan.bad && (plan.mem_read || plan.is_value)));

endmodule

// File: rtl/opaddr_idx_add.sv
module opaddr_idx_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] ofs,
    input  logic         en,
    output logic [W-1:0] sum
);

    logic [W-1:0] ofs_gated;

    always_comb begin
        ofs_gated = en ? ofs : '0;
        sum       = base + ofs_gated;
    end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_AW  = 3,
    parameter int IDX_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [DATA_W-1:0] instr_word0,
    input  logic [DATA_W-1:0] instr_word1,
    output logic [REG_AW-1:0] reg_sel,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              mem_rd_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              result_is_value,
    output logic              illegal
);

    localparam int MODE_W = 3;

    typedef struct packed {
        seq_e              st;
        amode_e            mode;
        logic [REG_AW-1:0] ix;
        logic [DATA_W-1:0] opf;
        logic [DATA_W-1:0] mar;
        logic [DATA_W-1:0] idx;
        logic              post;
        logic [DATA_W-1:0] res;
        logic              isval;
        logic              bad;
    } state_t;

    state_t s_d, s_q;
    plan_t  plan;
    logic [DATA_W-1:0] pre_sum;
    logic [DATA_W-1:0] post_sum;

    opaddr_decode u_decode (
        .mode (s_q.mode),
        .plan (plan)
    );

    opaddr_idx_add #(.W(DATA_W)) u_pre_add (
        .base (s_q.opf),
        .ofs  (reg_rdata),
        .en   (plan.add_before),
        .sum  (pre_sum)
    );

    opaddr_idx_add #(.W(DATA_W)) u_post_add (
        .base (mem_rdata),
        .ofs  (s_q.idx),
        .en   (s_q.post),
        .sum  (post_sum)
    );

    always_comb begin
        reg_sel = plan.from_reg ? s_q.opf[REG_AW-1:0] : s_q.ix;
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    s_d.mode  = amode_e'(instr_word0[MODE_W-1:0]);
                    s_d.ix    = instr_word0[IDX_LSB +: REG_AW];
                    s_d.opf   = instr_word1;
                    s_d.bad   = 1'b0;
                    s_d.isval = 1'b0;
                    s_d.post  = 1'b0;
                    s_d.st    = ST_CALC;
                end
            end
            ST_CALC: begin
                if (plan.bad) begin
                    s_d.bad = 1'b1;
                    s_d.st  = ST_DONE;
                end else if (plan.mem_read) begin
                    s_d.mar  = pre_sum;
                    s_d.idx  = reg_rdata;
                    s_d.post = plan.add_after;
                    s_d.st   = ST_READ;
                end else begin
                    s_d.res   = plan.from_reg ? reg_rdata : pre_sum;
                    s_d.isval = plan.is_value;
                    s_d.st    = ST_DONE;
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    s_d.res = post_sum;
                    s_d.st  = ST_DONE;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, mode: AM_LIT, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        instr_ready     = (s_q.st == ST_IDLE);
        mem_rd_req      = (s_q.st == ST_READ);
        mem_addr        = s_q.mar;
        done            = (s_q.st == ST_DONE);
        result          = s_q.res;
        result_is_value = s_q.isval;
        illegal         = done && s_q.bad;
    end

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_ready) |=> (mem_rd_req && $stable(mem_addr)));

    // R9
    read_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_ready) |=> (done && !mem_rd_req));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && instr_ready));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> (!mem_rd_req && !done));

    // R10
    illegal_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !$past(mem_rd_req)));

    // R2
    value_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_is_value) |-> !$past(mem_rd_req));

endmodule

// File: tb/opaddr_gen_tb_top.sv
module opaddr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [31:0] instr_word0 = '0;
    logic [31:0] instr_word1 = '0;
    logic [2:0]  reg_sel;
    logic [31:0] reg_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = 32'hDEAD_BEEF;
    logic        done;
    logic [31:0] result;
    logic        result_is_value;
    logic        illegal;

    int n_chk  = 0;
    int n_fail = 0;
    int lat    = 0;
    int wcnt   = 0;
    int nreads = 0;
    int cyc    = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] reg_base  = 32'h0000_0200;

    always #4 clk = ~clk;

    opaddr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_word0(instr_word0), .instr_word1(instr_word1),
        .reg_sel(reg_sel), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .result(result),
        .result_is_value(result_is_value), .illegal(illegal)
    );

    function automatic logic [31:0] regval(input logic [2:0] i);
        return reg_base + 32'(i) * 32'd113;
    endfunction

    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    always_comb reg_rdata = regval(reg_sel);

    always @(negedge clk) begin
        if (mem_rd_req && !mem_ready) begin
            if (wcnt == lat) begin
                mem_ready = 1'b1;
                mem_rdata = memval(mem_addr);
                last_addr = mem_addr;
                nreads++;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            mem_rdata = 32'hDEAD_BEEF;
            wcnt      = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w0, input logic [31:0] w1, input int l);
        logic [2:0]  md;
        logic [31:0] idx, exp;
        logic        isv;
        int          exp_reads, n;
        logic [31:0] exp_addr;
        md = w0[2:0];
        idx = regval(w0[10:8]);
        isv = 1'b0; exp_reads = 0; exp_addr = '0; exp = '0;
        case (md)
            3'd0: begin exp = w1; isv = 1'b1; end                               // R2
            3'd1: begin exp = regval(w1[2:0]); isv = 1'b1; end                  // R3
            3'd2: exp = w1;                                                     // R4
            3'd3: begin exp = memval(w1); exp_reads = 1; exp_addr = w1; end     // R5
            3'd4: exp = w1 + idx;                                               // R6
            3'd5: begin exp = memval(w1 + idx); exp_reads = 1; exp_addr = w1 + idx; end // R7
            3'd6: begin exp = memval(w1) + idx; exp_reads = 1; exp_addr = w1; end       // R8
            default: exp = '0;                                                  // R10
        endcase
        lat = l;
        nreads = 0;
        @(negedge clk);
        chk("R11 ready when idle", {31'b0, instr_ready}, 32'd1);
        instr_word0 = w0;
        instr_word1 = w1;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R11 busy after accept", {31'b0, instr_ready}, 32'd0);
        n = 0;
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 no done: actual 0 expected 1");
        end else begin
            chk($sformatf("R10 illegal mode %0d", md), {31'b0, illegal}, {31'b0, md == 3'd7});
            chk($sformatf("R9 read count mode %0d", md), 32'(nreads), 32'(exp_reads));
            if (md != 3'd7) begin
                chk($sformatf("R12 result mode %0d w0 %h w1 %h", md, w0, w1), result, exp);
                chk($sformatf("R2 value flag mode %0d", md), {31'b0, result_is_value}, {31'b0, isv});
            end
            if (exp_reads == 1)
                chk($sformatf("R9 read addr mode %0d", md), last_addr, exp_addr);
            @(negedge clk);
            chk("R11 done single cycle", {31'b0, done}, 32'd0);
            chk("R11 ready after done", {31'b0, instr_ready}, 32'd1);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] fields[4];
        int op;
        fields[0] = 32'h0000_0000;
        fields[1] = 32'd100;
        fields[2] = 32'hFFFF_FF40;
        fields[3] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 ready", {31'b0, instr_ready}, 32'd1);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 rd_req", {31'b0, mem_rd_req}, 32'd0);
        chk("R1 illegal", {31'b0, illegal}, 32'd0);
        rst_n = 1'b1;
        op = 0;
        for (int m = 0; m < 8; m++) begin
            for (int ix = 0; ix < 8; ix++) begin
                for (int f = 0; f < 4; f++) begin
                    logic [31:0] w0;
                    reg_base = 32'h0000_0200 + 32'(f) * 32'h0001_0007;
                    w0 = ((32'(op) * 32'h0101_7F35) & 32'hFFFF_F8F8)
                         | (32'(ix) << 8) | 32'(m);
                    run_op(w0, fields[f] + 32'(ix) * 32'(f == 3), op % 4);
                    op++;
                end
            end
        end
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule